// File: doc/BRIEF.md
# Link Test Pattern Generator

This block feeds the parallel side of a serial transmitter during a loopback test. While a run is active it produces a new 32-bit word every clock, taken from one of six pattern sources: four pseudo-random bit sequences of different lengths, a fastest-toggling clock-like pattern, and a slow square wave. Bit 0 of each word is the first bit sent on the line.

An operator can ask the block to damage one word. A single-cycle request flips the least significant bit of the word leaving in that cycle. The block counts every word it damages, and a clear input resets that count. A receiver-side checker can then compare its detected error count against this inserted count.

All pattern sources step together while a run is active, so changing the pattern select mid-run picks up the chosen source at its current position. When the run enable drops, every source goes back to its starting state. The next run therefore always begins at the start of its sequence.

Top module: `linktest_patgen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `tx_valid` is 0, `tx_data` is 0 and `err_count` is 0.
- R2: `tx_valid` follows `run_en` one clock later. Whenever `tx_valid` is 0, `tx_data` is all zeros.
- R3: Pattern select values 0, 1, 2 and 3 choose pseudo-random sequences with polynomials x^7+x^6+1, x^15+x^14+1, x^23+x^18+1 and x^31+x^28+1. For a register s of degree n with tap t, each new bit is s[n-1] xor s[t-1]. That bit is the next line bit, and it is shifted into s[0]. Word bit i is the i-th new bit of that cycle.
- R4: Every sequence register is loaded with all ones whenever `run_en` is 0. All four registers advance by 32 bits on every running cycle, whatever the pattern select is.
- R5: Pattern select 4 emits the alternating pattern starting with a 1 on the line, which is the word 0x55555555.
- R6: Pattern select 5 emits 33 ones followed by 33 zeros, repeating. The position is kept across word boundaries and starts at the first one when a run begins.
- R7: Pattern select values 6 and 7 emit all-zero words while `tx_valid` is still 1.
- R8: When `err_req` is high in a running cycle, bit 0 of the word registered in that cycle is inverted. All following words are the same as they would have been without the request.
- R9: `err_req` while `run_en` is 0 has no effect on `tx_data` or `err_count`.
- R10: `err_count` rises by exactly one for each word that is corrupted, and it is otherwise stable.
- R11: `cnt_clear` sets `err_count` to 0 on the next clock. It wins over a simultaneous insert: that word is still corrupted, but it is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Test run active |
| pat_sel | input | 3 | Pattern select (0..5 used) |
| err_req | input | 1 | Single-cycle error insert request |
| cnt_clear | input | 1 | Clears the inserted-error count |
| tx_data | output | 32 | Transmit word, bit 0 first on the line |
| tx_valid | output | 1 | Word valid |
| err_count | output | 16 | Number of corrupted words |

## Verification
A sequence register that steps wrongly, or that is not reseeded, shows up in the very next output word. Such a fault also keeps every later word in that mode wrong, so it cannot hide behind a single good sample. A low-frequency phase that slips by one bit moves the edge of the square wave within two words. An injection that reaches the register state instead of only the output shows up as a wrong word one cycle after the request. A wrong count or a lost clear shows on `err_count` one clock after the request or the clear.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [2:0] {
    PAT_P7  = 3'd0,
    PAT_P15 = 3'd1,
    PAT_P23 = 3'd2,
    PAT_P31 = 3'd3,
    PAT_HF  = 3'd4,
    PAT_LF  = 3'd5
  } pat_mode_e;

  localparam int NUM_PRBS = 4;
endpackage

// File: rtl/pg_prbs.sv
module pg_prbs #(
  parameter int DW  = 32,
  parameter int DEG = 7,
  parameter int TAP = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [DW-1:0] word
);
  localparam logic [DEG-1:0] SEED = '1;

  logic [DEG-1:0] st;
  logic [DEG-1:0] st_nxt;

  // Unrolled DW-step Fibonacci shift: each new bit goes to the line and into bit 0
  always_comb begin
    logic [DEG-1:0] s;
    logic           nb;
    s    = st;
    word = '0;
    for (int i = 0; i < DW; i++) begin
      nb      = s[DEG-1] ^ s[TAP-1];
      word[i] = nb;
      s       = {s[DEG-2:0], nb};
    end
    st_nxt = s;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) st <= SEED;
    else             st <= st_nxt;
  end
endmodule

// File: rtl/pg_lowfreq.sv
module pg_lowfreq #(
  parameter int DW   = 32,
  parameter int HALF = 33
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [DW-1:0] word
);
  localparam int PER = 2 * HALF;
  localparam int PW  = $clog2(PER);

  logic [PW-1:0] phase;
  logic [PW-1:0] phase_nxt;

  always_comb begin
    int p;
    word = '0;
    for (int i = 0; i < DW; i++) begin
      p       = (int'(phase) + i) % PER;
      word[i] = (p < HALF);
    end
    phase_nxt = PW'((int'(phase) + DW) % PER);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) phase <= '0;
    else             phase <= phase_nxt;
  end
endmodule

// File: rtl/pg_errcnt.sv
module pg_errcnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          hit,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (hit)     count <= count + 1'b1;
  end
endmodule

// File: rtl/linktest_patgen.sv
module linktest_patgen #(
  parameter int DW      = 32,
  parameter int CW      = 16,
  parameter int LF_HALF = 33
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic [2:0]    pat_sel,
  input  logic          err_req,
  input  logic          cnt_clear,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  output logic [CW-1:0] err_count
);
  import pg_pkg::*;

  localparam int PDEG [NUM_PRBS] = '{7, 15, 23, 31};
  localparam int PTAP [NUM_PRBS] = '{6, 14, 18, 28};
  localparam logic [DW-1:0] HF_WORD = {(DW/2){2'b01}};

  logic [DW-1:0] prbs_w [NUM_PRBS];
  logic [DW-1:0] lf_w;
  logic [DW-1:0] sel_w;
  logic          inject;

  for (genvar g = 0; g < NUM_PRBS; g++) begin : g_prbs
    pg_prbs #(.DW(DW), .DEG(PDEG[g]), .TAP(PTAP[g])) u_prbs (
      .clk  (clk),
      .rst  (rst),
      .run  (run_en),
      .word (prbs_w[g])
    );
  end

  pg_lowfreq #(.DW(DW), .HALF(LF_HALF)) u_lf (
    .clk  (clk),
    .rst  (rst),
    .run  (run_en),
    .word (lf_w)
  );

  assign inject = run_en && err_req;

  pg_errcnt #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (cnt_clear),
    .hit   (inject),
    .count (err_count)
  );

  always_comb begin
    case (pat_mode_e'(pat_sel))
      PAT_P7:  sel_w = prbs_w[0];
      PAT_P15: sel_w = prbs_w[1];
      PAT_P23: sel_w = prbs_w[2];
      PAT_P31: sel_w = prbs_w[3];
      PAT_HF:  sel_w = HF_WORD;
      PAT_LF:  sel_w = lf_w;
      default: sel_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data  <= '0;
      tx_valid <= 1'b0;
    end else begin
      tx_valid <= run_en;
      tx_data  <= run_en ? (sel_w ^ {{(DW-1){1'b0}}, inject}) : '0;
    end
  end
endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          run_en,
  input logic [2:0]    pat_sel,
  input logic          err_req,
  input logic          cnt_clear,
  input logic [DW-1:0] tx_data,
  input logic          tx_valid,
  input logic [CW-1:0] err_count
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!tx_valid && tx_data == '0 && err_count == '0));

  assert_valid_on_R2: assert property (@(posedge clk) disable iff (rst)
    run_en |=> tx_valid);

  assert_valid_off_R2: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !tx_valid);

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !tx_valid |-> tx_data == '0);

  assert_hf_word_R5: assert property (@(posedge clk) disable iff (rst)
    (run_en && pat_sel == 3'd4 && !err_req) |=> tx_data == {(DW/2){2'b01}});

  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (run_en && pat_sel[2:1] == 2'b11 && !err_req) |=> tx_data == '0);

  assert_count_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clear && !(run_en && err_req)) |=> $stable(err_count));

  assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clear && run_en && err_req) |=> err_count == $past(err_count) + 1'b1);

  assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
    cnt_clear |=> err_count == '0);
endmodule

bind linktest_patgen pg_checker #(.DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run_en    (run_en),
  .pat_sel   (pat_sel),
  .err_req   (err_req),
  .cnt_clear (cnt_clear),
  .tx_data   (tx_data),
  .tx_valid  (tx_valid),
  .err_count (err_count)
);

// File: tb/sim_linktest_patgen.sv
module sim_linktest_patgen;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int CW = 16;

  typedef struct {
    logic          valid;
    logic [DW-1:0] data;
    logic [CW-1:0] cnt;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run_en = 1'b0;
  logic [2:0]    pat_sel = 3'd0;
  logic          err_req = 1'b0;
  logic          cnt_clear = 1'b0;
  logic [DW-1:0] tx_data;
  logic          tx_valid;
  logic [CW-1:0] err_count;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];

  // reference model state
  logic [30:0]   ms [4];
  int            mdeg [4] = '{7, 15, 23, 31};
  int            mtap [4] = '{6, 14, 18, 28};
  int            lf_ph = 0;
  logic [CW-1:0] mcnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  linktest_patgen u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .pat_sel(pat_sel),
    .err_req(err_req), .cnt_clear(cnt_clear),
    .tx_data(tx_data), .tx_valid(tx_valid), .err_count(err_count)
  );

  task automatic reseed();
    for (int k = 0; k < 4; k++) ms[k] = (31'd1 << mdeg[k]) - 31'd1;
    lf_ph = 0;
  endtask

  // Builds one word per source and advances every source (R3, R4, R6)
  task automatic model_words(output logic [DW-1:0] w [6]);
    for (int k = 0; k < 4; k++) begin
      logic [30:0] mask;
      mask = (31'd1 << mdeg[k]) - 31'd1;
      w[k] = '0;
      for (int b = 0; b < DW; b++) begin
        logic nb;
        nb   = ms[k][mdeg[k]-1] ^ ms[k][mtap[k]-1];
        w[k][b] = nb;
        ms[k] = ((ms[k] << 1) | {30'd0, nb}) & mask;
      end
    end
    w[4] = 32'h5555_5555;
    w[5] = '0;
    for (int b = 0; b < DW; b++) w[5][b] = (((lf_ph + b) % 66) < 33);
    lf_ph = (lf_ph + DW) % 66;
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic run, input logic [2:0] sel,
                      input logic err, input logic clr, input string tag);
    exp_t e;
    logic [DW-1:0] w [6];
    @(negedge clk);
    run_en = run; pat_sel = sel; err_req = err; cnt_clear = clr;
    e.tag = tag;
    if (run) begin
      model_words(w);
      e.valid = 1'b1;
      e.data  = (sel <= 3'd5) ? w[sel] : '0;
      if (err) e.data[0] = ~e.data[0];
    end else begin
      reseed();
      e.valid = 1'b0;
      e.data  = '0;
    end
    if (clr) mcnt = '0;
    else if (run && err) mcnt = mcnt + 1'b1;
    e.cnt = mcnt;
    q.push_back(e);
  endtask

  // Monitor: compares each registered result after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (tx_valid !== e.valid || tx_data !== e.data || err_count !== e.cnt) begin
          fails++;
          $display("FAIL %s: valid=%0b data=%08h cnt=%0d expected valid=%0b data=%08h cnt=%0d",
                   e.tag, tx_valid, tx_data, err_count, e.valid, e.data, e.cnt);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    reseed();
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (tx_valid !== 1'b0 || tx_data !== '0 || err_count !== '0) begin
      fails++;
      $display("FAIL R1: valid=%0b data=%08h cnt=%0d expected 0/0/0", tx_valid, tx_data, err_count);
    end
    @(negedge clk);
    rst = 1'b0;

    // R9: insert while idle is ignored; R2 idle words are zero
    step(0, 3'd0, 0, 0, "R2");
    step(0, 3'd0, 1, 0, "R9");
    step(0, 3'd5, 1, 0, "R9");
    // R3: each polynomial, switching mid-run (R4 parallel advance)
    for (int i = 0; i < 12; i++) step(1, 3'd0, 0, 0, "R3");
    for (int i = 0; i < 6;  i++) step(1, 3'd1, 0, 0, "R4");
    for (int i = 0; i < 6;  i++) step(1, 3'd2, 0, 0, "R3");
    for (int i = 0; i < 6;  i++) step(1, 3'd3, 0, 0, "R3");
    // R4: a new run restarts from the seed
    step(0, 3'd3, 0, 0, "R2");
    for (int i = 0; i < 4; i++) step(1, 3'd3, 0, 0, "R4");
    // R8, R10: insert into PRBS words, later words unaffected
    step(1, 3'd3, 1, 0, "R8");
    step(1, 3'd3, 0, 0, "R8");
    step(1, 3'd0, 1, 0, "R10");
    step(1, 3'd0, 1, 0, "R10");
    step(1, 3'd0, 0, 0, "R8");
    // R5: alternating pattern, with an insert
    for (int i = 0; i < 3; i++) step(1, 3'd4, 0, 0, "R5");
    step(1, 3'd4, 1, 0, "R8");
    step(1, 3'd4, 0, 0, "R5");
    // R6: slow square wave from a fresh run
    step(0, 3'd5, 0, 0, "R2");
    for (int i = 0; i < 10; i++) step(1, 3'd5, 0, 0, "R6");
    // R7: unused selects
    step(1, 3'd6, 0, 0, "R7");
    step(1, 3'd7, 0, 0, "R7");
    // R11: clear, and clear together with insert
    step(1, 3'd1, 0, 1, "R11");
    step(1, 3'd1, 1, 0, "R10");
    step(1, 3'd1, 1, 1, "R11");
    step(0, 3'd1, 0, 0, "R11");
    step(0, 3'd1, 0, 0, "R2");
    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule